// File: doc/BRIEF.md
# Shared-Adder ALU with Truth-Table Logic

This block is a 16-bit arithmetic and logic unit. A single carry-chain adder handles every arithmetic operation: plain and carry-chained addition, subtraction, negation, increment, decrement and a one-place left shift. Three things around that adder make this possible. An operand selector picks the adder's second input. An inverter can complement either adder input. A carry-in selector supplies 0, 1, the external carry or its complement.

Bitwise logic does not use dedicated gates. Each result bit is looked up in a four-entry truth table, indexed by that bit's A and B values. The four function bits of the opcode are the table contents, so any of the sixteen two-input Boolean functions can be selected.

The opcode fields drive these controls directly, with no decode stage. The result and four status flags are captured in one output register stage.

Opcode encoding (8 bits):
- bit 7 is the mode: 0 for arithmetic, 1 for logic.
- bit 6 enables inversion.
- bits 5:4 select the carry-in.
- bits 3:0 are the function field.

Top module: `alu_shared_core`

## Requirements
- R1: While `rst_n` is low, `result` and all four flags are 0.
- R2: In arithmetic mode the adder computes X + Y + cin. X is A.
  - Y is selected by function bits 1:0: 00 gives B, 01 gives A, 10 gives zero, 11 gives all ones.
  - cin is selected by opcode bits 5:4: 00 gives 0, 01 gives 1, 10 gives `carry_in`, 11 gives the complement of `carry_in`.
  - `flag_carry` is the carry out of bit 15.
  - When opcode bit 6 is 1, function bit 2 picks which adder input is complemented: 0 complements Y, 1 complements X.
- R3: Opcode 0x50 yields A - B. `flag_carry` is 1 exactly when A >= B (unsigned).
- R4: Opcode 0x56 yields the two's-complement negation of A.
- R5: Opcode 0x12 yields A + 1, and opcode 0x03 yields A - 1, both modulo 2^16.
- R6: Opcode 0x01 yields A shifted left by one place, computed as A + A. `flag_carry` equals A[15].
- R7: In logic mode, result bit i equals function bit {A[i], B[i]}. Thus 0x88 gives AND, 0x8E gives OR, 0x86 gives XOR and 0x83 gives NOT A.
- R8: In logic mode, opcode bits 6:4 and `carry_in` have no effect on the result, and `flag_carry` and `flag_ovf` are 0.
- R9: `flag_zero` is 1 exactly when all 16 result bits are 0, and `flag_neg` equals result bit 15.
- R10: In arithmetic mode, `flag_ovf` is 1 when both adder inputs, after any inversion, share a sign bit that differs from the sum's bit 15.
- R11: In arithmetic mode, function bit 3 has no effect on any output.
- R12: Inputs sampled at a rising clock edge appear on the outputs right after that edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opcode | input | 8 | Mode, invert, carry-in select, function field |
| a | input | 16 | Operand A |
| b | input | 16 | Operand B |
| carry_in | input | 1 | Supplied carry for chained arithmetic |
| result | output | 16 | Registered result |
| flag_carry | output | 1 | Adder carry-out (0 in logic mode) |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Result bit 15 |
| flag_ovf | output | 1 | Signed overflow (0 in logic mode) |

## Verification
Every result and flag is due one clock edge after its opcode and operands are presented. Nothing else in the block carries state, so no output takes longer.

The bench drives inputs on the falling edge and samples the outputs on the following falling edge, which lies after exactly one rising edge. It compares them there against a model built from the encodings above.

For the hold behaviour, the bench changes the inputs just after that sample point and checks again before the next rising edge. The outputs must not have moved.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // carry-in select field (opcode bits 5:4)
    localparam logic [1:0] CIN_ZERO  = 2'b00;
    localparam logic [1:0] CIN_ONE   = 2'b01;
    localparam logic [1:0] CIN_EXT   = 2'b10;
    localparam logic [1:0] CIN_EXT_N = 2'b11;

    // second adder operand select (function bits 1:0 in arithmetic mode)
    localparam logic [1:0] YSEL_B    = 2'b00;
    localparam logic [1:0] YSEL_A    = 2'b01;
    localparam logic [1:0] YSEL_ZERO = 2'b10;
    localparam logic [1:0] YSEL_ONES = 2'b11;

    typedef struct packed {
        logic       logic_mode;
        logic       invert;
        logic [1:0] cin_sel;
        logic [3:0] fn;
    } opcode_t;

endpackage

// File: rtl/alu_operand_path.sv
module alu_operand_path #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             invert,
    input  logic [2:0]       fn_ctl,
    output logic [WIDTH-1:0] x_op,
    output logic [WIDTH-1:0] y_op
);
    import alu_pkg::*;

    logic [WIDTH-1:0] y_raw;

    always_comb begin
        unique case (fn_ctl[1:0])
            YSEL_B:    y_raw = b;
            YSEL_A:    y_raw = a;
            YSEL_ZERO: y_raw = '0;
            default:   y_raw = '1;
        endcase
    end

    // fn_ctl[2] chooses which adder input the inverter acts on
    always_comb begin
        x_op = a;
        y_op = y_raw;
        if (invert) begin
            if (fn_ctl[2]) x_op = ~a;
            else           y_op = ~y_raw;
        end
    end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_op,
    input  logic [WIDTH-1:0] y_op,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic prop;
        assign prop         = x_op[i] ^ y_op[i];
        assign sum[i]       = prop ^ chain[i];
        assign chain[i+1]   = (x_op[i] & y_op[i]) | (prop & chain[i]);
    end

    assign cout = chain[WIDTH];

endmodule

// File: rtl/alu_truth_table.sv
module alu_truth_table #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       table_bits,
    output logic [WIDTH-1:0] f
);
    // each bit indexes the shared 4-entry table with its own {a,b}
    for (genvar i = 0; i < WIDTH; i++) begin : g_lut
        assign f[i] = table_bits[{a[i], b[i]}];
    end

endmodule

// File: rtl/alu_shared_core.sv
module alu_shared_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       opcode,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             flag_carry,
    output logic             flag_zero,
    output logic             flag_neg,
    output logic             flag_ovf
);
    import alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             c;
        logic             z;
        logic             n;
        logic             v;
    } out_state_t;

    opcode_t          op;
    logic [WIDTH-1:0] x_op, y_op, sum, lut_out;
    logic             cin, cout;
    out_state_t       state_d, state_q;

    assign op = opcode_t'(opcode);

    alu_operand_path #(.WIDTH(WIDTH)) u_operands (
        .a      (a),
        .b      (b),
        .invert (op.invert),
        .fn_ctl (op.fn[2:0]),
        .x_op   (x_op),
        .y_op   (y_op)
    );

    always_comb begin
        unique case (op.cin_sel)
            CIN_ZERO: cin = 1'b0;
            CIN_ONE:  cin = 1'b1;
            CIN_EXT:  cin = carry_in;
            default:  cin = ~carry_in;
        endcase
    end

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .x_op (x_op),
        .y_op (y_op),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    alu_truth_table #(.WIDTH(WIDTH)) u_table (
        .a          (a),
        .b          (b),
        .table_bits (op.fn),
        .f          (lut_out)
    );

    always_comb begin
        state_d = '0;
        if (op.logic_mode) begin
            state_d.res = lut_out;
            state_d.c   = 1'b0;
            state_d.v   = 1'b0;
        end else begin
            state_d.res = sum;
            state_d.c   = cout;
            state_d.v   = (x_op[MSB] == y_op[MSB]) && (sum[MSB] != x_op[MSB]);
        end
        state_d.z = ~|state_d.res;
        state_d.n = state_d.res[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result     = state_q.res;
    assign flag_carry = state_q.c;
    assign flag_zero  = state_q.z;
    assign flag_neg   = state_q.n;
    assign flag_ovf   = state_q.v;

    // R2: plain add with zero carry-in
    a_r2_plain_add: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h00) |=> ({flag_carry, result} == ({1'b0, $past(a)} + {1'b0, $past(b)})));

    // R3: subtract opcode
    a_r3_subtract: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h50) |=> (result == ($past(a) - $past(b))));

    // R6: shift left via A + A
    a_r6_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h01) |=> ((result == ($past(a) << 1)) && (flag_carry == $past(a[MSB]))));

    // R7: AND through the truth table
    a_r7_and_table: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h88) |=> (result == ($past(a) & $past(b))));

    // R8: logic mode clears carry and overflow
    a_r8_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        opcode[7] |=> (!flag_carry && !flag_ovf));

endmodule

// File: tb/tb_alu_shared_core.sv
module tb_alu_shared_core;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   opcode = '0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         flag_carry, flag_zero, flag_neg, flag_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu_shared_core #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .a(a), .b(b),
        .carry_in(carry_in), .result(result), .flag_carry(flag_carry),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h (op %h a %h b %h ci %b)",
                     tag, got, exp, opcode, a, b, carry_in);
        end
    endtask

    // returns {ovf, neg, zero, carry, result}
    function automatic logic [W+3:0] model(input logic [7:0] op, input logic [W-1:0] aa,
                                           input logic [W-1:0] bb, input logic ci);
        logic [W-1:0] x, y, r;
        logic         c, v, cinv;
        logic [W:0]   s;
        if (op[7]) begin
            for (int i = 0; i < W; i++) r[i] = op[{aa[i], bb[i]}];
            c = 1'b0;
            v = 1'b0;
        end else begin
            x = aa;
            case (op[1:0])
                2'b00: y = bb;
                2'b01: y = aa;
                2'b10: y = '0;
                default: y = '1;
            endcase
            if (op[6]) begin
                if (op[2]) x = ~x;
                else       y = ~y;
            end
            case (op[5:4])
                2'b00: cinv = 1'b0;
                2'b01: cinv = 1'b1;
                2'b10: cinv = ci;
                default: cinv = ~ci;
            endcase
            s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cinv};
            r = s[W-1:0];
            c = s[W];
            v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
        end
        return {v, r[W-1], (r == '0), c, r};
    endfunction

    task automatic apply(input logic [7:0] op, input logic [W-1:0] aa,
                         input logic [W-1:0] bb, input logic ci);
        @(negedge clk);
        opcode = op; a = aa; b = bb; carry_in = ci;
        @(negedge clk);
    endtask

    task automatic check_all(input string rtag, input string ftag);
        logic [W+3:0] e;
        e = model(opcode, a, b, carry_in);
        check(rtag, 32'(result), 32'(e[W-1:0]));
        check(rtag, 32'(flag_carry), 32'(e[W]));
        check(ftag, 32'(flag_zero), 32'(e[W+1]));
        check(ftag, 32'(flag_neg), 32'(e[W+2]));
        check(opcode[7] ? "R8" : "R10", 32'(flag_ovf), 32'(e[W+3]));
    endtask

    function automatic logic [W-1:0] pat_a(input int k);
        case (k)
            0: return 16'h0000; 1: return 16'hFFFF; 2: return 16'h7FFF; 3: return 16'h8000;
            4: return 16'h1234; 5: return 16'hA5A5; 6: return 16'h8000; default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [W-1:0] pat_b(input int k);
        case (k)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'h0001; 3: return 16'h8000;
            4: return 16'hABCD; 5: return 16'h5A5A; 6: return 16'h0001; default: return 16'hFFFF;
        endcase
    endfunction

    initial begin
        logic [W-1:0] hold_r;
        logic [7:0]   ref_op;

        // R1: reset state
        opcode = 8'h00; a = 16'h1111; b = 16'h2222;
        repeat (3) @(negedge clk);
        check("R1", 32'({result, flag_carry, flag_zero, flag_neg, flag_ovf}), 32'h0);
        rst_n = 1'b1;

        // R3: subtract, borrow rule
        apply(8'h50, 16'h0005, 16'h0003, 1'b0);
        check("R3", 32'(result), 32'h0002);
        check("R3", 32'(flag_carry), 32'h1);
        apply(8'h50, 16'h0003, 16'h0005, 1'b0);
        check("R3", 32'(result), 32'hFFFE);
        check("R3", 32'(flag_carry), 32'h0);

        // R4: negate
        apply(8'h56, 16'h0001, 16'h7777, 1'b1);
        check("R4", 32'(result), 32'hFFFF);
        apply(8'h56, 16'h8000, 16'h0000, 1'b0);
        check("R4", 32'(result), 32'h8000);

        // R5: increment and decrement wrap
        apply(8'h12, 16'hFFFF, 16'h1234, 1'b0);
        check("R5", 32'(result), 32'h0000);
        check("R9", 32'(flag_zero), 32'h1);
        apply(8'h03, 16'h0000, 16'h1234, 1'b1);
        check("R5", 32'(result), 32'hFFFF);
        check("R9", 32'(flag_neg), 32'h1);

        // R6: shift left
        apply(8'h01, 16'hC001, 16'h0000, 1'b0);
        check("R6", 32'(result), 32'h8002);
        check("R6", 32'(flag_carry), 32'h1);

        // R10: signed overflow cases
        apply(8'h00, 16'h7FFF, 16'h0001, 1'b0);
        check("R10", 32'(flag_ovf), 32'h1);
        apply(8'h00, 16'h8000, 16'h8000, 1'b0);
        check("R10", 32'(flag_ovf), 32'h1);
        check("R9", 32'(flag_zero), 32'h1);
        apply(8'h00, 16'h7FFF, 16'h8000, 1'b0);
        check("R10", 32'(flag_ovf), 32'h0);

        // R7: named logic functions
        apply(8'h88, 16'hF0F0, 16'hCCCC, 1'b0);
        check("R7", 32'(result), 32'hC0C0);
        apply(8'h8E, 16'hF0F0, 16'hCCCC, 1'b0);
        check("R7", 32'(result), 32'hFCFC);
        apply(8'h86, 16'hF0F0, 16'hCCCC, 1'b0);
        check("R7", 32'(result), 32'h3C3C);
        apply(8'h83, 16'hF0F0, 16'hCCCC, 1'b0);
        check("R7", 32'(result), 32'h0F0F);

        // R8: control bits 6:4 and carry_in ignored in logic mode
        for (int k = 0; k < 16; k++) begin
            apply({1'b1, 3'(k[2:0]), 4'h6}, 16'h1357, 16'hFEDC, k[3]);
            check("R8", 32'(result), 32'(16'h1357 ^ 16'hFEDC));
            check("R8", 32'({flag_carry, flag_ovf}), 32'h0);
        end

        // R11: function bit 3 ignored in arithmetic mode
        for (int k = 0; k < 8; k++) begin
            ref_op = {1'b0, 3'(k), 4'h5};
            apply(ref_op, 16'h9ABC, 16'h4321, 1'b1);
            hold_r = result;
            apply(ref_op | 8'h08, 16'h9ABC, 16'h4321, 1'b1);
            check("R11", 32'(result), 32'(hold_r));
        end

        // R12: output registered, holds while inputs change mid-cycle
        apply(8'h00, 16'h0010, 16'h0020, 1'b0);
        check("R12", 32'(result), 32'h0030);
        opcode = 8'h8F; a = 16'h5555; b = 16'hAAAA;
        #3;
        check("R12", 32'(result), 32'h0030);
        @(posedge clk); #1;
        check("R12", 32'(result), 32'hFFFF);

        // R2, R9, R10: sweep every opcode over operand patterns and carry values
        for (int op = 0; op < 256; op++) begin
            for (int k = 0; k < 8; k++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    apply(8'(op), pat_a(k), pat_b(k), ci[0]);
                    check_all(op[7] ? "R7" : "R2", "R9");
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule